// File: doc/BRIEF.md
# SMBus Slave Memory Write Command Engine

This block is the transaction layer of an SMBus slave. A bit-level receiver in front of it turns the bus into a stream of byte-level events: start, stop and received byte. A repeated start arrives as a start that comes before any stop. For every received byte the engine gives an ACK or NACK decision. When a byte is meant for storage, the engine also drives a one-cycle write strobe toward a 128-byte RAM or toward a 512-byte nonvolatile array. The nonvolatile array has a programming-busy timer.

The command byte that follows the slave address selects one of four operations:

- a RAM byte write, or a RAM pointer load when no data byte follows;
- a nonvolatile pointer setup;
- a nonvolatile byte write;
- a block write of up to a parameterised number of bytes.

One shared pointer records which store a block write goes to and where it starts. The pointer is only committed when a transaction ends at a stop or a repeated start, and it survives both.

The event input is a valid/ready stream. `ev_ready` is held high, so the engine never applies back-pressure. An event is consumed on every clock edge where `ev_valid` is high. The producer may leave gaps between events of any length. A slow nonvolatile store is reported through the per-byte NACK, not by stalling the stream. `nv_wr_en` and `nv_busy` are plain level signals.

Top module: `smb_mem_cmd_engine`

## Requirements
- R1: The first byte after a start is acknowledged only when bits 7:1 equal `SLV_ADDR` and bit 0 is 0. Otherwise it is NACKed, and every further byte up to the next start or stop is NACKed with no write.
- R2: A command in 00h–7Fh followed by one data byte writes that byte to RAM at the command value. Any later data byte in the same transaction is NACKed and writes nothing.
- R3: A command in 00h–7Fh that is ended by stop or start with no data byte sets the pointer to RAM at that address. It writes nothing.
- R4: A command of 80h or 81h followed by exactly one data byte and then stop or start sets the pointer to the nonvolatile store. The pointer address is command bit 0 followed by the data byte, a 9-bit value. Nothing is written.
- R5: A command of 80h or 81h followed by two data bytes writes the second byte to nonvolatile address {command bit 0, first data byte}. This happens only when `nv_wr_en` is 1 and `nv_busy` is 0. Otherwise the second byte is NACKed and nothing is written.
- R6: After command A0h the next byte is a count. A count of 1 to `MAX_BLK` is ACKed. A count of 0 or above `MAX_BLK` is NACKed, and all bytes up to the next stop or start are NACKed.
- R7: Each block data byte is written at the pointer into the store the pointer selects, and the pointer then advances by one. The address wraps at 7 bits for RAM and at 9 bits for the nonvolatile store. Bytes beyond the count are NACKed.
- R8: The pointer is kept across stop and across repeated start. Only R3, R4 and accepted R7 bytes change it.
- R9: Every nonvolatile write sets `nv_busy` for `NV_BUSY_CYC` cycles, starting in the cycle of the strobe. A nonvolatile data byte that arrives while the store is busy, or while `nv_wr_en` is 0, is NACKed, writes nothing, and does not advance the pointer or use up the count.
- R10: Commands other than 00h–81h and A0h are NACKed, and the rest of that transaction is NACKed.
- R11: `ev_ready` is always 1. Each byte event (`ev_kind` = 2) produces exactly one `ack_valid` pulse in the following cycle, with `ack_ok` = 1 for ACK. Write strobes appear in that same cycle, at most one per cycle. `ev_kind` 0 is start, 1 is stop, and 3 is ignored.
- R12: Byte events after reset or after a stop, before any start, are NACKed and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Always 1, so the engine never stalls |
| ev_kind | input | 2 | 0 start, 1 stop, 2 byte, 3 ignored |
| ev_byte | input | 8 | Received byte for a byte event |
| nv_wr_en | input | 1 | Nonvolatile write permission |
| ack_valid | output | 1 | One-cycle pulse carrying a byte's response |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 7 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| nv_we | output | 1 | Nonvolatile write strobe |
| nv_addr | output | 9 | Nonvolatile write address |
| nv_wdata | output | 8 | Nonvolatile write data |
| nv_busy | output | 1 | Nonvolatile programming in progress |

## Verification
A wrong transaction phase shows up at `ack_ok` on the very next byte. Examples are a command read as data, or a count that was not armed: the response one cycle after that byte flips between ACK and NACK. A corrupt pointer stays hidden until the next block write, and then the first strobe carries the wrong address or selects the wrong store. A miscounted busy timer shows up as a NACK or ACK mismatch on the first nonvolatile byte sent near the end of the busy window, and as a difference in `nv_busy` on the exact cycle it clears. A behavioural model in the bench predicts every output on every cycle, so each of these is seen on the first cycle it differs.

// File: rtl/smb_cmd_pkg.sv
package smb_cmd_pkg;
  localparam int RAM_AW = 7;
  localparam int NV_AW  = 9;

  typedef enum logic [1:0] {
    EV_START = 2'd0,
    EV_STOP  = 2'd1,
    EV_BYTE  = 2'd2,
    EV_NONE  = 2'd3
  } ev_kind_e;

  typedef enum logic [2:0] {
    ST_SKIP, ST_ADDR, ST_CMD, ST_DAT1, ST_DAT2, ST_CNT, ST_BLK
  } phase_e;

  localparam logic [7:0] CMD_NV0   = 8'h80;
  localparam logic [7:0] CMD_NV1   = 8'h81;
  localparam logic [7:0] CMD_BLOCK = 8'hA0;
endpackage

// File: rtl/smb_nv_timer.sv
module smb_nv_timer #(
  parameter int BUSY_CYC = 17500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R9: counter never exceeds its load value
  a_r9_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);
  // R9: a start always yields busy in the next cycle
  a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/smb_cmd_fsm.sv
module smb_cmd_fsm
  import smb_cmd_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h2A,
  parameter int         MAX_BLK  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_fire,
  input  ev_kind_e          ev_kind,
  input  logic [7:0]        ev_byte,
  input  logic              nv_wr_en,
  input  logic              nv_busy,
  output logic              nv_start,
  output logic              ack_valid,
  output logic              ack_ok,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              nv_we,
  output logic [NV_AW-1:0]  nv_addr,
  output logic [7:0]        nv_wdata
);
  localparam int CW = $clog2(MAX_BLK + 1);
  localparam logic [7:0] MAXB = 8'(MAX_BLK);
  localparam int PADW = NV_AW - RAM_AW;

  phase_e            st_q, st_d;
  logic [7:0]        cmd_q, cmd_d, lo_q, lo_d;
  logic [CW-1:0]     left_q, left_d;
  logic              pnv_q, pnv_d;
  logic [NV_AW-1:0]  ptr_q, ptr_d;
  logic              av_d, ok_d, rwe_d, nwe_d;
  logic [RAM_AW-1:0] ra_d;
  logic [NV_AW-1:0]  na_d;

  always_comb begin
    st_d = st_q; cmd_d = cmd_q; lo_d = lo_q; left_d = left_q;
    pnv_d = pnv_q; ptr_d = ptr_q;
    av_d = 1'b0; ok_d = 1'b0; rwe_d = 1'b0; nwe_d = 1'b0;
    ra_d = '0; na_d = '0;
    if (ev_fire) begin
      case (ev_kind)
        EV_START, EV_STOP: begin
          if (st_q == ST_DAT1 && !cmd_q[7]) begin
            pnv_d = 1'b0;
            ptr_d = {{PADW{1'b0}}, cmd_q[RAM_AW-1:0]};
          end
          if (st_q == ST_DAT2) begin
            pnv_d = 1'b1;
            ptr_d = {cmd_q[0], lo_q};
          end
          st_d = (ev_kind == EV_START) ? ST_ADDR : ST_SKIP;
        end
        EV_BYTE: begin
          av_d = 1'b1;
          case (st_q)
            ST_ADDR: begin
              if (ev_byte[7:1] == SLV_ADDR && !ev_byte[0]) begin
                ok_d = 1'b1; st_d = ST_CMD;
              end else st_d = ST_SKIP;
            end
            ST_CMD: begin
              cmd_d = ev_byte;
              if (!ev_byte[7] || ev_byte == CMD_NV0 || ev_byte == CMD_NV1) begin
                ok_d = 1'b1; st_d = ST_DAT1;
              end else if (ev_byte == CMD_BLOCK) begin
                ok_d = 1'b1; st_d = ST_CNT;
              end else st_d = ST_SKIP;
            end
            ST_DAT1: begin
              ok_d = 1'b1;
              if (!cmd_q[7]) begin
                rwe_d = 1'b1; ra_d = cmd_q[RAM_AW-1:0]; st_d = ST_SKIP;
              end else begin
                lo_d = ev_byte; st_d = ST_DAT2;
              end
            end
            ST_DAT2: begin
              if (nv_wr_en && !nv_busy) begin
                nwe_d = 1'b1; ok_d = 1'b1; na_d = {cmd_q[0], lo_q};
              end
              st_d = ST_SKIP;
            end
            ST_CNT: begin
              if (ev_byte != 8'd0 && ev_byte <= MAXB) begin
                ok_d = 1'b1; left_d = ev_byte[CW-1:0]; st_d = ST_BLK;
              end else st_d = ST_SKIP;
            end
            ST_BLK: begin
              if (left_q != '0) begin
                if (!pnv_q) begin
                  rwe_d = 1'b1; ok_d = 1'b1; ra_d = ptr_q[RAM_AW-1:0];
                  ptr_d = {{PADW{1'b0}}, ptr_q[RAM_AW-1:0] + 1'b1};
                  left_d = left_q - 1'b1;
                end else if (nv_wr_en && !nv_busy) begin
                  nwe_d = 1'b1; ok_d = 1'b1; na_d = ptr_q;
                  ptr_d = ptr_q + 1'b1;
                  left_d = left_q - 1'b1;
                end
              end
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign nv_start = nwe_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_SKIP; cmd_q <= '0; lo_q <= '0; left_q <= '0;
      pnv_q <= 1'b0; ptr_q <= '0;
      ack_valid <= 1'b0; ack_ok <= 1'b0;
      ram_we <= 1'b0; ram_addr <= '0; ram_wdata <= '0;
      nv_we <= 1'b0; nv_addr <= '0; nv_wdata <= '0;
    end else begin
      st_q <= st_d; cmd_q <= cmd_d; lo_q <= lo_d; left_q <= left_d;
      pnv_q <= pnv_d; ptr_q <= ptr_d;
      ack_valid <= av_d; ack_ok <= ok_d;
      ram_we <= rwe_d; ram_addr <= ra_d; ram_wdata <= ev_byte;
      nv_we <= nwe_d; nv_addr <= na_d; nv_wdata <= ev_byte;
    end
  end

  // R11: a response only follows an accepted byte event
  a_r11_ack_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(ev_fire && ev_kind == EV_BYTE));
  // R6: remaining count never exceeds the block limit
  a_r6_left_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= CW'(MAX_BLK));
  // R8: pointer only moves on an event
  a_r8_ptr_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ev_fire) |-> $stable(ptr_q));
endmodule

// File: rtl/smb_mem_cmd_engine.sv
module smb_mem_cmd_engine
  import smb_cmd_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR    = 7'h2A,
  parameter int         MAX_BLK     = 32,
  parameter int         NV_BUSY_CYC = 17500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_valid,
  output logic       ev_ready,
  input  logic [1:0] ev_kind,
  input  logic [7:0] ev_byte,
  input  logic       nv_wr_en,
  output logic       ack_valid,
  output logic       ack_ok,
  output logic       ram_we,
  output logic [6:0] ram_addr,
  output logic [7:0] ram_wdata,
  output logic       nv_we,
  output logic [8:0] nv_addr,
  output logic [7:0] nv_wdata,
  output logic       nv_busy
);
  logic nv_start;

  assign ev_ready = 1'b1;

  smb_cmd_fsm #(.SLV_ADDR(SLV_ADDR), .MAX_BLK(MAX_BLK)) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .ev_fire(ev_valid), .ev_kind(ev_kind_e'(ev_kind)), .ev_byte(ev_byte),
    .nv_wr_en(nv_wr_en), .nv_busy(nv_busy), .nv_start(nv_start),
    .ack_valid(ack_valid), .ack_ok(ack_ok),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .nv_we(nv_we), .nv_addr(nv_addr), .nv_wdata(nv_wdata)
  );

  smb_nv_timer #(.BUSY_CYC(NV_BUSY_CYC)) tmr_i (
    .clk(clk), .rst_n(rst_n), .start(nv_start), .busy(nv_busy)
  );

  // R11: never two strobes in one cycle
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, nv_we}));
  // R7: every write strobe is paired with an ACK
  a_r7_strobe_acked: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || nv_we) |-> (ack_valid && ack_ok));
  // R5: nonvolatile write needs permission
  a_r5_nv_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |-> $past(nv_wr_en));
  // R9: no nonvolatile write while the store was busy
  a_r9_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |-> (!$past(nv_busy) && nv_busy));
endmodule

// File: tb/smb_mem_cmd_engine_tb.sv
module smb_mem_cmd_engine_tb_top;
  localparam logic [6:0] SA = 7'h2A;
  localparam int BUSY = 40;
  localparam logic [7:0] AW = {SA, 1'b0};

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       ev_valid = 1'b0;
  logic [1:0] ev_kind = 2'd0;
  logic [7:0] ev_byte = 8'd0;
  logic       nv_wr_en = 1'b0;
  logic       ev_ready, ack_valid, ack_ok, ram_we, nv_we, nv_busy;
  logic [6:0] ram_addr;
  logic [8:0] nv_addr;
  logic [7:0] ram_wdata, nv_wdata;

  smb_mem_cmd_engine #(.SLV_ADDR(SA), .MAX_BLK(32), .NV_BUSY_CYC(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_byte(ev_byte), .nv_wr_en(nv_wr_en),
    .ack_valid(ack_valid), .ack_ok(ack_ok),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .nv_we(nv_we), .nv_addr(nv_addr), .nv_wdata(nv_wdata), .nv_busy(nv_busy)
  );

  int total = 0, bad = 0;
  string cur_req = "R11";

  // behavioural reference model
  int nb = -1, cmd = 0, lo = 0, left = 0, p_addr = 0, busy_left = 0;
  bit alive = 0, p_nv = 0, bz = 0, ok = 0;
  bit e_av = 0, e_ok = 0, e_rwe = 0, e_nwe = 0;
  int e_ra = 0, e_rd = 0, e_na = 0, e_nd = 0;

  always @(posedge clk) begin
    e_av = 0; e_ok = 0; e_rwe = 0; e_nwe = 0;
    if (!rst_n) begin
      nb = -1; alive = 0; p_nv = 0; p_addr = 0; busy_left = 0;
    end else begin
      bz = (busy_left > 0);
      if (ev_valid && (ev_kind == 2'd0 || ev_kind == 2'd1)) begin
        if (alive && nb == 2 && cmd < 128) begin p_nv = 0; p_addr = cmd; end
        if (alive && nb == 3 && (cmd == 128 || cmd == 129)) begin
          p_nv = 1; p_addr = (cmd - 128) * 256 + lo;
        end
        nb = (ev_kind == 2'd0) ? 0 : -1;
        alive = (ev_kind == 2'd0);
      end else if (ev_valid && ev_kind == 2'd2) begin
        e_av = 1; ok = 0;
        if (!alive) ok = 0;
        else if (nb == 0) begin
          ok = (ev_byte == AW); alive = ok;
        end else if (nb == 1) begin
          cmd = ev_byte;
          ok = (cmd < 128 || cmd == 128 || cmd == 129 || cmd == 160); alive = ok;
        end else if (nb == 2) begin
          if (cmd < 128) begin
            e_rwe = 1; e_ra = cmd; e_rd = ev_byte; ok = 1; alive = 0;
          end else if (cmd == 160) begin
            ok = (ev_byte >= 1 && ev_byte <= 32); left = ev_byte; alive = ok;
          end else begin
            lo = ev_byte; ok = 1;
          end
        end else if (cmd == 160) begin
          if (left > 0) begin
            if (!p_nv) begin
              e_rwe = 1; e_ra = p_addr; e_rd = ev_byte; ok = 1;
              p_addr = (p_addr + 1) % 128; left--;
            end else if (nv_wr_en && !bz) begin
              e_nwe = 1; e_na = p_addr; e_nd = ev_byte; ok = 1;
              p_addr = (p_addr + 1) % 512; left--;
            end
          end
        end else begin
          if (nv_wr_en && !bz) begin
            e_nwe = 1; e_na = (cmd - 128) * 256 + lo; e_nd = ev_byte; ok = 1;
          end
          alive = 0;
        end
        e_ok = ok;
        if (alive && nb < 3) nb++;
      end
      if (e_nwe) busy_left = BUSY;
      else if (busy_left > 0) busy_left--;
    end
  end

  task automatic chk(input bit good, input string what, input int act, input int exp);
    total++;
    if (!good) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(ev_ready == 1'b1, "ev_ready", int'(ev_ready), 1);
    chk(ack_valid == e_av, "ack_valid", int'(ack_valid), int'(e_av));
    if (e_av) chk(ack_ok == e_ok, "ack_ok", int'(ack_ok), int'(e_ok));
    chk(ram_we == e_rwe, "ram_we", int'(ram_we), int'(e_rwe));
    if (e_rwe) begin
      chk(int'(ram_addr) == e_ra, "ram_addr", int'(ram_addr), e_ra);
      chk(int'(ram_wdata) == e_rd, "ram_wdata", int'(ram_wdata), e_rd);
    end
    chk(nv_we == e_nwe, "nv_we", int'(nv_we), int'(e_nwe));
    if (e_nwe) begin
      chk(int'(nv_addr) == e_na, "nv_addr", int'(nv_addr), e_na);
      chk(int'(nv_wdata) == e_nd, "nv_wdata", int'(nv_wdata), e_nd);
    end
    chk(nv_busy == (busy_left > 0), "nv_busy", int'(nv_busy), int'(busy_left > 0));
  end

  task automatic ev(input logic [1:0] k, input logic [7:0] b);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask
  task automatic st(); ev(2'd0, 8'h00); endtask
  task automatic sp(); ev(2'd1, 8'h00); endtask
  task automatic by(input logic [7:0] b); ev(2'd2, b); endtask

  bit done = 0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cur_req = "R11"; // reset state
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    cur_req = "R12"; // bytes with no start
    by(AW); by(8'h10); by(8'h33);
    ev(2'd3, 8'hFF); // R11: kind 3 ignored

    cur_req = "R1"; // wrong address, then read bit set
    st(); by({7'h2B, 1'b0}); by(8'h10); by(8'h44); sp();
    st(); by({SA, 1'b1}); by(8'h10); by(8'h44); sp();

    cur_req = "R2";
    st(); by(AW); by(8'h10); by(8'h55); by(8'h66); sp();
    st(); by(AW); by(8'h7F); by(8'hA5); sp();

    cur_req = "R3"; // send-byte pointer, then block with RAM wrap
    st(); by(AW); by(8'h7E); sp();
    cur_req = "R7";
    st(); by(AW); by(8'hA0); by(8'd4);
    by(8'h01); by(8'h02); by(8'h03); by(8'h04); by(8'h05); sp();

    cur_req = "R8"; // pointer across repeated start and stop
    st(); by(AW); by(8'h05);
    st(); by(AW); by(8'hA0); by(8'd2); by(8'hC1); by(8'hC2); sp();
    st(); by(AW); by(8'hA0); by(8'd1); by(8'hC3); sp();

    cur_req = "R10";
    st(); by(AW); by(8'h90); by(8'h01); sp();
    st(); by(AW); by(8'hA1); by(8'h01); sp();
    st(); by(AW); by(8'hFF); sp();

    cur_req = "R6";
    st(); by(AW); by(8'hA0); by(8'd0); by(8'h11); sp();
    st(); by(AW); by(8'hA0); by(8'd33); by(8'h11); sp();
    st(); by(AW); by(8'h20); sp();
    st(); by(AW); by(8'hA0); by(8'd32);
    for (int i = 0; i < 33; i++) by(8'(i + 8'h40));
    sp();

    cur_req = "R5"; // nonvolatile byte write, enabled then disabled
    nv_wr_en = 1'b1;
    st(); by(AW); by(8'h80); by(8'h10); by(8'hAB); sp();
    cur_req = "R9";
    st(); by(AW); by(8'h81); by(8'h22); by(8'hCD); sp(); // busy -> NACK
    repeat (BUSY + 4) @(negedge clk);
    cur_req = "R5";
    nv_wr_en = 1'b0;
    st(); by(AW); by(8'h81); by(8'h20); by(8'hCD); sp();
    nv_wr_en = 1'b1;

    cur_req = "R4"; // pointer setup, repeated start, block with 9-bit wrap
    st(); by(AW); by(8'h81); by(8'hFF);
    st(); by(AW); by(8'hA0); by(8'd2);
    cur_req = "R9";
    by(8'h91); by(8'h92); // second arrives while busy
    repeat (BUSY + 2) @(negedge clk);
    cur_req = "R7";
    by(8'h93); by(8'h94); sp();
    repeat (BUSY + 2) @(negedge clk);
    cur_req = "R4";
    st(); by(AW); by(8'h80); by(8'h07); sp();
    nv_wr_en = 1'b0;
    st(); by(AW); by(8'hA0); by(8'd1); by(8'h77); sp(); // disabled
    nv_wr_en = 1'b1;
    st(); by(AW); by(8'hA0); by(8'd1); by(8'h78); sp(); // writes at 007
    repeat (BUSY + 4) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule